// File: doc/BRIEF.md
# E1 Transmit Highway Slot Multiplexer

This block sits on the transmit side of an E1 framer, ahead of framing and line coding. Two serial system-highway lines arrive in bit lockstep: a payload line and a signaling line. For every 8-bit time slot of the 32-slot frame, the block picks which line to sample and sends the chosen bit out as one merged serial stream. A bit-position counter tracks the frame. A frame sync pulse aligns it by loading a programmable offset, and between pulses it runs freely on the system clock.

A small register-write port programs three things: a per-slot marker mask (one bit per slot), a mode word and the sync offset. A marker bit of one routes the signaling line for that slot, and zero routes the payload line. That routing applies only while multiplexing is enabled and serial signaling mode is off. In every other case the payload line passes through. Mask and mode writes are held in a staging copy and only take effect at the next slot boundary, so no slot is ever split between the two sources.

The merged output is a plain TDM stream: `out_valid` marks bits that belong to an aligned frame, and `out_slot` gives the slot each bit came from. The serial highway cannot pause, so the stream has no ready input and no back-pressure. Every valid bit must be taken in the cycle it is presented.

Top module: `tx_hwy_slot_mux`

## Requirements
- R1: While `rst_n` is low and at the first sample after it, `out_valid`, `out_bit` and `out_slot` are all 0. After reset the mask is 0, the mode is 0 (multiplexing disabled) and the offset is 0.
- R2: If `sync_in` is high at a clock edge, the bit sampled at that edge takes frame position equal to the programmed offset (0..255), and `out_slot` then shows offset divided by 8. A change of offset only matters at the next sync.
- R3: Between sync pulses, the position advances by one each clock and wraps from 255 to 0. The slot is position/8, so it wraps from 31 to 0, and the bit index within the slot wraps from 7 to 0.
- R4: The output is registered. The bit sampled at one edge appears on `out_bit`/`out_slot` after that edge. `out_valid` stays 0 until the first sync has been sampled, and is 1 at every sample from then on.
- R5: With mode bit 0 (multiplex enable) clear, `out_bit` always equals the payload input `data_in`.
- R6: With mode bit 1 (serial signaling mode) set, `out_bit` equals `data_in`, whatever the enable bit says.
- R7: With multiplexing enabled and serial signaling mode off, a slot whose marker bit is 1 outputs the signaling input `sig_in`.
- R8: With multiplexing enabled and serial signaling mode off, a slot whose marker bit is 0 outputs `data_in`.
- R9: Write address k (0..3) sets the marker bits for slots 8k..8k+7, with data bit i going to slot 8k+i. Address 4 holds the mode: bit 0 is the enable and bit 1 is serial signaling mode. Address 5 holds the sync offset.
- R10: A mask or mode write reaches the selection only after the edge that samples bit 7 of a slot. The rest of the current slot keeps the old selection, and the next slot's first bit uses the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame sync pulse, loads the offset into the position counter |
| data_in | input | 1 | Serial payload highway bit |
| sig_in | input | 1 | Serial signaling highway bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0..3 mask, 4 mode, 5 offset) |
| wr_data | input | 8 | Register write data |
| out_valid | output | 1 | Merged bit belongs to an aligned frame |
| out_bit | output | 1 | Merged serial output bit |
| out_slot | output | 5 | Time slot of the merged bit |

## Verification
Several rules are checked by assertions on every cycle. After a sync, the output slot must be the offset's slot; without a sync, it must follow the free-running counter. When multiplexing is disabled or overridden, the output must copy the payload line. The active mask and mode may change only on the edge that closes a slot, and valid may only rise after a sync. Other behaviours need the bench's scenarios, which set up the register state in a known order. These are the address-to-slot mapping of the mask registers, the mid-slot write that must leave the rest of its slot unchanged, offset values that wrap the frame, and the signaling-versus-payload choice under fixed and random line patterns.

// File: rtl/tx_hwy_mux_pkg.sv
package tx_hwy_mux_pkg;
  // Width of one configuration register.
  localparam int REG_W = 8;

  // Mode word: bit 0 enables per-slot multiplexing, bit 1 forces payload (serial signaling).
  typedef struct packed {
    logic cas_serial;
    logic mux_en;
  } mux_mode_t;

  localparam int MODE_W = $bits(mux_mode_t);
endpackage

// File: rtl/tx_mux_cfg.sv
module tx_mux_cfg
  import tx_hwy_mux_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int POS_W = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             commit,
  output logic [SLOTS-1:0] act_mask,
  output mux_mode_t        act_mode,
  output logic [POS_W-1:0] offset_q
);
  localparam int MASK_REGS = SLOTS / REG_W;
  localparam logic [AW-1:0] MODE_ADDR = AW'(MASK_REGS);
  localparam logic [AW-1:0] OFFS_ADDR = AW'(MASK_REGS + 1);

  logic [SLOTS-1:0] stage_mask;
  mux_mode_t        stage_mode;

  // One staging byte per mask register.
  for (genvar g = 0; g < MASK_REGS; g++) begin : g_mask_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_mask[g*REG_W +: REG_W] <= '0;
      end else if (wr_en && wr_addr == AW'(g)) begin
        stage_mask[g*REG_W +: REG_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_mode <= '0;
      offset_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == MODE_ADDR) stage_mode <= mux_mode_t'(wr_data[MODE_W-1:0]);
      if (wr_addr == OFFS_ADDR) offset_q   <= POS_W'(wr_data);
    end
  end

  // Staged values move to the active copy only at a slot boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask <= '0;
      act_mode <= '0;
    end else if (commit) begin
      act_mask <= stage_mask;
      act_mode <= stage_mode;
    end
  end
endmodule

// File: rtl/tx_mux_timing.sv
module tx_mux_timing #(
  parameter int POS_W = 8,
  parameter int BIT_W = 3,
  parameter int FRAME = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [POS_W-1:0] offset,
  output logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] pos_q,
  output logic             slot_end,
  output logic             aligned_q
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME - 1);

  // Position of the bit sampled at this edge.
  assign cur_pos  = sync_in ? offset : pos_q;
  assign slot_end = &cur_pos[BIT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else begin
      pos_q <= (cur_pos == LAST_POS) ? '0 : cur_pos + POS_W'(1);
      if (sync_in) aligned_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_mux_select.sv
module tx_mux_select
  import tx_hwy_mux_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [SLOTS-1:0]  act_mask,
  input  mux_mode_t         act_mode,
  input  logic              data_in,
  input  logic              sig_in,
  output logic              pick_bit
);
  logic use_sig;

  always_comb begin
    use_sig  = act_mode.mux_en && !act_mode.cas_serial && act_mask[cur_slot];
    pick_bit = use_sig ? sig_in : data_in;
  end
endmodule

// File: rtl/tx_hwy_slot_mux.sv
module tx_hwy_slot_mux
  import tx_hwy_mux_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int AW        = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic                     data_in,
  input  logic                     sig_in,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [7:0]               wr_data,
  output logic                     out_valid,
  output logic                     out_bit,
  output logic [$clog2(SLOTS)-1:0] out_slot
);
  localparam int FRAME  = SLOTS * SLOT_BITS;
  localparam int POS_W  = $clog2(FRAME);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] offset_q;
  logic             slot_end;
  logic             aligned_q;
  logic [SLOTS-1:0] act_mask;
  mux_mode_t        act_mode;
  logic             pick_bit;
  logic [SLOT_W-1:0] cur_slot;

  assign cur_slot = cur_pos[POS_W-1:BIT_W];

  tx_mux_cfg #(.SLOTS(SLOTS), .POS_W(POS_W), .AW(AW)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .commit   (slot_end),
    .act_mask (act_mask),
    .act_mode (act_mode),
    .offset_q (offset_q)
  );

  tx_mux_timing #(.POS_W(POS_W), .BIT_W(BIT_W), .FRAME(FRAME)) tim_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .offset    (offset_q),
    .cur_pos   (cur_pos),
    .pos_q     (pos_q),
    .slot_end  (slot_end),
    .aligned_q (aligned_q)
  );

  tx_mux_select #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) sel_i (
    .cur_slot (cur_slot),
    .act_mask (act_mask),
    .act_mode (act_mode),
    .data_in  (data_in),
    .sig_in   (sig_in),
    .pick_bit (pick_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_slot  <= '0;
    end else begin
      out_valid <= aligned_q || sync_in;
      out_bit   <= pick_bit;
      out_slot  <= cur_slot;
    end
  end
endmodule

// File: rtl/tx_hwy_slot_mux_chk.sv
module tx_hwy_slot_mux_chk #(
  parameter int SLOTS  = 32,
  parameter int POS_W  = 8,
  parameter int BIT_W  = 3,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_in,
  input logic              data_in,
  input logic              out_valid,
  input logic              out_bit,
  input logic [SLOT_W-1:0] out_slot,
  input logic [POS_W-1:0]  offset_q,
  input logic [POS_W-1:0]  pos_q,
  input logic              slot_end,
  input logic [SLOTS-1:0]  act_mask,
  input logic [1:0]        act_mode_bits
);
  // R2: a sync places the sampled bit in the offset's slot
  p_sync_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> out_slot == $past(offset_q[POS_W-1:BIT_W]));

  // R3: without sync the slot follows the free-running counter
  p_free_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_in |=> out_slot == $past(pos_q[POS_W-1:BIT_W]));

  // R4: valid can only rise after a sync has been sampled
  p_valid_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(sync_in));

  // R5 and R6: disabled or overridden multiplexing passes payload
  p_payload_pass_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_mode_bits[0] || act_mode_bits[1]) |=> out_bit == $past(data_in));

  // R10: active mask changes only on the edge closing a slot
  p_mask_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mask) |-> $past(slot_end));

  // R10: active mode changes only on the edge closing a slot
  p_mode_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode_bits) |-> $past(slot_end));
endmodule

bind tx_hwy_slot_mux tx_hwy_slot_mux_chk #(
  .SLOTS(SLOTS), .POS_W(POS_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_in       (sync_in),
  .data_in       (data_in),
  .out_valid     (out_valid),
  .out_bit       (out_bit),
  .out_slot      (out_slot),
  .offset_q      (offset_q),
  .pos_q         (pos_q),
  .slot_end      (slot_end),
  .act_mask      (act_mask),
  .act_mode_bits (act_mode)
);

// File: tb/tx_hwy_slot_mux_tb_top.sv
module tx_hwy_slot_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       data_in = 1'b0;
  logic       sig_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       out_valid;
  logic       out_bit;
  logic [4:0] out_slot;

  always #5 clk = ~clk;

  tx_hwy_slot_mux dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .data_in(data_in),
    .sig_in(sig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_bit(out_bit), .out_slot(out_slot)
  );

  typedef struct {
    logic  v;
    logic  b;
    int    slot;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit fixed_lines = 0;   // when set: payload 0, signaling 1

  // Reference model state, built from the requirements
  int        m_pos = 0, m_off = 0;
  bit [31:0] m_stage = '0, m_act = '0;
  bit        m_en_s = 0, m_cas_s = 0, m_en = 0, m_cas = 0;
  bit        m_aligned = 0;

  task automatic check_item(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pop the oldest expected item and compare with the outputs
  task automatic monitor_pop();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    check_item(e.tag, "out_valid", int'(out_valid), int'(e.v));
    if (e.v) begin
      check_item(e.tag, "out_bit", int'(out_bit), int'(e.b));
      check_item(e.tag, "out_slot", int'(out_slot), e.slot);
    end
  endtask

  // Driver: apply one cycle of inputs and push the expected result
  task automatic step(input bit sync, input bit we, input logic [2:0] addr,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    int   cur;
    bit   d, s, use_sig;
    @(negedge clk);
    monitor_pop();
    d = fixed_lines ? 1'b0 : 1'($urandom);
    s = fixed_lines ? 1'b1 : 1'($urandom);
    sync_in = sync; data_in = d; sig_in = s;
    wr_en = we; wr_addr = addr; wr_data = wd;
    cur = sync ? m_off : m_pos;
    use_sig = m_en && !m_cas && m_act[cur/8];
    e.v = m_aligned || sync;
    e.b = use_sig ? s : d;
    e.slot = cur / 8;
    e.tag = tag;
    exp_q.push_back(e);
    if (cur % 8 == 7) begin
      m_act = m_stage; m_en = m_en_s; m_cas = m_cas_s;
    end
    if (we) begin
      if (addr < 4) m_stage[addr*8 +: 8] = wd;
      else if (addr == 4) begin m_en_s = wd[0]; m_cas_s = wd[1]; end
      else if (addr == 5) m_off = int'(wd);
    end
    m_pos = (cur + 1) % 256;
    m_aligned = e.v;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 8'd0, tag);
  endtask

  task automatic wr(input logic [2:0] addr, input logic [7:0] wd, input string tag);
    step(0, 1, addr, wd, tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_item("R1", "out_valid in reset", int'(out_valid), 0);
    check_item("R1", "out_bit in reset", int'(out_bit), 0);
    check_item("R1", "out_slot in reset", int'(out_slot), 0);
    rst_n = 1'b1;

    // R4: no valid before the first sync; R5: reset mode passes payload
    idle(20, "R4");
    // R2: first sync with reset offset 0; R5 over two frames with random lines
    step(1, 0, 3'd0, 8'd0, "R2");
    idle(511, "R5");

    // R9: mask bytes and mode word; R7 and R8 with random lines
    wr(3'd0, 8'hA5, "R9");
    wr(3'd1, 8'h3C, "R9");
    wr(3'd2, 8'h0F, "R9");
    wr(3'd3, 8'h81, "R9");
    wr(3'd4, 8'h01, "R9");
    idle(520, "R7");
    // R8 with fixed lines so every slot's source is visible
    fixed_lines = 1;
    idle(256, "R8");

    // R6: serial signaling mode overrides the enable
    wr(3'd4, 8'h03, "R6");
    idle(300, "R6");
    wr(3'd4, 8'h01, "R6");
    idle(16, "R7");

    // R2 and R3: offset that lands mid-slot, then wrap across frame end
    wr(3'd5, 8'd77, "R2");
    idle(10, "R2");
    step(1, 0, 3'd0, 8'd0, "R2");
    idle(300, "R3");
    wr(3'd5, 8'd255, "R3");
    step(1, 0, 3'd0, 8'd0, "R3");
    idle(40, "R3");

    // R10: mid-slot mask write; re-sync with offset 0 first
    wr(3'd5, 8'd0, "R10");
    wr(3'd0, 8'h00, "R10");
    step(1, 0, 3'd0, 8'd0, "R10");
    idle(50, "R10");
    while (m_pos != 42) idle(1, "R10");
    wr(3'd0, 8'h20, "R10");   // slot 5 marker, written at slot 5 bit 2
    idle(20, "R10");
    wr(3'd4, 8'h00, "R10");   // mode change mid-slot
    idle(20, "R10");

    // R5 with random lines after disabling
    fixed_lines = 0;
    idle(100, "R5");

    @(negedge clk);
    monitor_pop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule